// File: doc/BRIEF.md
# Light-Load Burst Sleep and Retry Controller

This block decides when a primary-side switching regulator should stop switching at light load, and when it should try again. In normal operation it holds switching enabled while a quantised error-amplifier (COMP) level stays above a burst threshold less a hysteresis margin. Once COMP drops to that margin or below, switching stops and the block raises a low-consumption flag.

While asleep, the block counts a fixed period. At the end of each period it requests exactly one probe switching pulse so the output can be resampled. Once the gate logic reports that the probe pulse has ended, the block waits a fixed settling time and then reads COMP once. If COMP is above a lower wake level, normal switching resumes. Otherwise the block sleeps for another full period. A level rising above any threshold during sleep does not wake the block; only the probe-and-check sequence does. Each burst pulse therefore carries the same energy, and the load sets only how often the pulses come. A global halt input forces the block into a reset state with every output low and the timer cleared.

Top module: `burst_sleep_ctl`

## Requirements
- R1: After reset, and in every cycle following a cycle with `halt` high, all three outputs are low. On the first clock edge with `halt` low after that, the block enters normal switching.
- R2: In normal switching, `sw_en` is 1, and `low_pwr` and `probe_req` are 0. The block stays there while `comp_code` is greater than ENTER = BURST_CODE - HYST_CODE (93 with the defaults).
- R3: A clock edge in normal switching with `comp_code` <= ENTER moves the block to sleep, where `sw_en` = 0 and `low_pwr` = 1.
- R4: During the sleep period, `comp_code` (at any value) and `probe_done` have no effect. `sw_en` stays 0 and `low_pwr` stays 1.
- R5: `probe_req` rises exactly PERIOD_CYC cycles after sleep was entered, and it stays high until a cycle with `probe_done` high. While `probe_req` is high, `sw_en` = 0 and `low_pwr` = 1.
- R6: COMP is read on the SETTLE_CYC-th clock edge after the edge that saw `probe_done`. If `comp_code` > WAKE_CODE at that edge, normal switching resumes.
- R7: If `comp_code` <= WAKE_CODE at that reading, the block returns to sleep and starts a complete new period of PERIOD_CYC cycles. Values of `comp_code` during the settling cycles have no effect.
- R8: A `halt` during sleep clears the period timer. A later entry into sleep waits a full PERIOD_CYC cycles before the probe.
- R9: `sw_en` and `low_pwr` are never high together, and `probe_req` is high only while `low_pwr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt | input | 1 | Synchronous global disable; clears state and timer |
| comp_code | input | CODE_W | Quantised error-amplifier level |
| probe_done | input | 1 | Strobe from gate timing: the probe pulse has ended |
| sw_en | output | 1 | Normal switching enabled |
| probe_req | output | 1 | Request for one probe switching pulse |
| low_pwr | output | 1 | Low-consumption sleep flag |

## Verification
The bench places COMP exactly at ENTER and one code above it, and exactly at WAKE_CODE and one code above it. An off-by-one comparison would then sleep too early, or wake on a level that should keep the block asleep. During sleep and settling it drives a high COMP and stray `probe_done` strobes. A design that woke on a simple threshold crossing, or sampled COMP before settling ended, would raise `sw_en` early. It times the probe to the exact cycle, both after a failed retry and after a halt in mid-sleep. A timer that was not restarted or cleared would then fire the probe early.

// File: rtl/burst_sleep_ctl.sv
module burst_sleep_ctl #(
  parameter int CODE_W     = 8,
  parameter int BURST_CODE = 100,
  parameter int HYST_CODE  = 7,
  parameter int WAKE_CODE  = 70,
  parameter int PERIOD_CYC = 100000,
  parameter int SETTLE_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt,
  input  logic [CODE_W-1:0] comp_code,
  input  logic              probe_done,
  output logic              sw_en,
  output logic              probe_req,
  output logic              low_pwr
);

  localparam int MAX_CNT = (PERIOD_CYC > SETTLE_CYC) ? PERIOD_CYC : SETTLE_CYC;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);
  localparam logic [CODE_W-1:0] ENTER_LVL = CODE_W'(BURST_CODE - HYST_CODE);
  localparam logic [CODE_W-1:0] WAKE_LVL  = CODE_W'(WAKE_CODE);
  localparam logic [CNT_W-1:0]  PER_LAST  = CNT_W'(PERIOD_CYC - 1);
  localparam logic [CNT_W-1:0]  SET_LAST  = CNT_W'(SETTLE_CYC - 1);

  typedef enum logic [2:0] {S_OFF, S_RUN, S_IDLE, S_PROBE, S_SETTLE} state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_OFF;
      cnt   <= '0;
    end else if (halt) begin
      state <= S_OFF;
      cnt   <= '0;
    end else begin
      case (state)
        S_OFF: begin
          state <= S_RUN;
          cnt   <= '0;
        end
        S_RUN: begin
          cnt <= '0;
          if (comp_code <= ENTER_LVL) state <= S_IDLE;
        end
        S_IDLE: begin
          if (cnt == PER_LAST) begin
            state <= S_PROBE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_PROBE: begin
          cnt <= '0;
          if (probe_done) state <= S_SETTLE;
        end
        S_SETTLE: begin
          if (cnt == SET_LAST) begin
            state <= (comp_code > WAKE_LVL) ? S_RUN : S_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state <= S_OFF;
          cnt   <= '0;
        end
      endcase
    end
  end

  assign sw_en     = (state == S_RUN);
  assign probe_req = (state == S_PROBE);
  assign low_pwr   = (state == S_IDLE) || (state == S_PROBE) || (state == S_SETTLE);

endmodule

module burst_sleep_ctl_chk #(
  parameter int CODE_W     = 8,
  parameter int ENTER_CODE = 93
) (
  input logic              clk,
  input logic              rst_n,
  input logic              halt,
  input logic [CODE_W-1:0] comp_code,
  input logic              probe_done,
  input logic              sw_en,
  input logic              probe_req,
  input logic              low_pwr
);

  assert_halt_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (!sw_en && !probe_req && !low_pwr));

  assert_enter_sleep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && !halt && (comp_code <= CODE_W'(ENTER_CODE))) |=> (low_pwr && !sw_en));

  assert_probe_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_req && !probe_done && !halt) |=> probe_req);

  assert_probe_from_sleep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(probe_req) |-> ($past(low_pwr) && !$past(sw_en)));

  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_en && low_pwr));

  assert_probe_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    probe_req |-> low_pwr);

endmodule

bind burst_sleep_ctl burst_sleep_ctl_chk #(
  .CODE_W(CODE_W),
  .ENTER_CODE(BURST_CODE - HYST_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .halt(halt), .comp_code(comp_code),
  .probe_done(probe_done), .sw_en(sw_en), .probe_req(probe_req), .low_pwr(low_pwr)
);

// File: tb/burst_sleep_ctl_test.sv
module burst_sleep_ctl_test;
  localparam int PER = 8;
  localparam int SET = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt = 1'b0;
  logic [7:0] comp_code = 8'd120;
  logic probe_done = 1'b0;
  logic sw_en, probe_req, low_pwr;

  int checks = 0;
  int errors = 0;
  bit ended = 0;

  typedef struct {
    bit sw;
    bit pr;
    bit lo;
    string tag;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  burst_sleep_ctl #(
    .PERIOD_CYC(PER),
    .SETTLE_CYC(SET)
  ) uut (
    .clk(clk), .rst_n(rst_n), .halt(halt), .comp_code(comp_code),
    .probe_done(probe_done), .sw_en(sw_en), .probe_req(probe_req), .low_pwr(low_pwr)
  );

  task automatic compare(input bit sw, input bit pr, input bit lo, input string tag);
    checks++;
    if (sw_en !== sw || probe_req !== pr || low_pwr !== lo) begin
      errors++;
      $display("FAIL %s: got sw/probe/low=%b%b%b expected %b%b%b", tag,
               sw_en, probe_req, low_pwr, sw, pr, lo);
    end
  endtask

  task automatic expect_next(input bit sw, input bit pr, input bit lo, input string tag);
    exp_t e;
    e.sw = sw; e.pr = pr; e.lo = lo; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic step(input int c, input bit done, input bit h,
                      input bit sw, input bit pr, input bit lo, input string tag);
    @(negedge clk);
    comp_code  = 8'(c);
    probe_done = done;
    halt       = h;
    expect_next(sw, pr, lo, tag);
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      compare(e.sw, e.pr, e.lo, e.tag);
    end
  end

  task automatic finish_run;
    if (!ended) begin
      ended = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #50000;
    checks++;
    errors++;
    $display("FAIL watchdog: got hang expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    compare(0, 0, 0, "R1 reset");
    rst_n = 1'b1;
    expect_next(1, 0, 0, "R1 leave reset");
    step(94, 1, 0, 1, 0, 0, "R2 one above enter level");
    step(94, 0, 0, 1, 0, 0, "R2 hold");
    step(93, 0, 0, 0, 0, 1, "R3 enter sleep at level");
    for (int i = 0; i < PER - 1; i++) step(200, i[0], 0, 0, 0, 1, "R4 sleep ignores inputs");
    step(200, 0, 0, 0, 1, 1, "R5 probe after period");
    step(200, 0, 0, 0, 1, 1, "R5 probe held");
    step(200, 0, 0, 0, 1, 1, "R5 probe held");
    step(200, 1, 0, 0, 0, 1, "R6 probe done");
    for (int i = 0; i < SET - 1; i++) step(200, 0, 0, 0, 0, 1, "R7 settle ignores comp");
    step(70, 0, 0, 0, 0, 1, "R7 at wake level stays asleep");
    for (int i = 0; i < PER - 1; i++) step(200, 0, 0, 0, 0, 1, "R7 new period");
    step(200, 0, 0, 0, 1, 1, "R7 second probe");
    step(200, 1, 0, 0, 0, 1, "R6 probe done");
    for (int i = 0; i < SET - 1; i++) step(0, 0, 0, 0, 0, 1, "R6 settle");
    step(71, 0, 0, 1, 0, 0, "R6 wake above level");
    step(120, 0, 1, 0, 0, 0, "R1 halt");
    step(0, 0, 1, 0, 0, 0, "R1 halt held");
    step(50, 0, 0, 1, 0, 0, "R1 leave halt");
    step(50, 0, 0, 0, 0, 1, "R3 enter sleep");
    for (int i = 0; i < 3; i++) step(50, 0, 0, 0, 0, 1, "R8 partial sleep");
    step(50, 0, 1, 0, 0, 0, "R8 halt in sleep");
    step(50, 0, 0, 1, 0, 0, "R8 leave halt");
    step(50, 0, 0, 0, 0, 1, "R8 re-enter sleep");
    for (int i = 0; i < PER - 1; i++) step(50, 0, 0, 0, 0, 1, "R8 full period");
    step(50, 0, 0, 0, 1, 1, "R8 probe after cleared timer");
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule